// File: doc/BRIEF.md
# ATM Cell Transmit Port (PHY side)

This block is the receiving end of a cell-level parallel bus on which an ATM layer device hands outgoing cells to a physical-layer device. The writer presents one word per clock with a write enable, marks the first word of every cell with a start-of-cell strobe, and sends a parity bit with each word. The block checks that parity, gathers the words of each cell into one slot of a four-cell store, and hands complete cells to a downstream cell processor through a simple word-by-word read port.

Flow control works by polling. The writer places a 5-bit PHY address on the bus. One clock later the block drives its cell-available flag, but only if that address is its own. The flag is split into an enable and a value so that the tri-state behaviour can be observed without bidirectional nets. The bus width is fixed per instance by a parameter. An 8-bit port takes 53 words per cell. A 16-bit port takes 27 words per cell: 54 octets, the last of which is a filler.

Top module: `cellport_tx`

## Requirements
- R1: After reset, clav_oe, clav_val, par_err and rd_avail are all 0.
- R2: clav_oe becomes 1 at the first rising edge at which tx_addr equals PHY_ADDR. It becomes 0 at the first rising edge at which tx_addr differs from PHY_ADDR.
- R3: clav_val is 1 only while clav_oe is 1 and fewer than 4 complete cells are stored. It drops at the same edge that stores the fourth cell.
- R4: A cell is 53 words when DW=8 and 27 words when DW=16. rd_avail rises at the edge that accepts the last word of a cell.
- R5: The read port returns the words of each cell in write order, and cells leave in arrival order. rd_soc is 1 while the first word of a cell is presented. Each rd_en high while rd_avail is 1 advances the port by one word.
- R6: With cfg_odd=1 a word is correct when the XOR of all data bits and tx_par is 1. With cfg_odd=0 that XOR must be 0. A wrong word sets par_err, which stays 1 until reset. The word is still stored.
- R7: A start-of-cell inside an unfinished cell throws away the partial cell, and the new cell is stored from word 0.
- R8: A cell whose start-of-cell arrives while 4 cells are stored is dropped entirely. The stored cells are not changed.
- R9: Words with tx_wen=0 are ignored. Words with tx_wen=1 that arrive outside a cell without start-of-cell are also ignored.
- R10: rd_en while rd_avail is 0 has no effect. When a cell completes on the write side in the same cycle that one finishes reading, the stored-cell count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_addr | input | 5 | Polled PHY address |
| tx_wen | input | 1 | Word write enable |
| tx_soc | input | 1 | Start-of-cell marker |
| tx_data | input | DW | Cell data word |
| tx_par | input | 1 | Parity bit for tx_data |
| clav_oe | output | 1 | Drive enable of cell-available flag |
| clav_val | output | 1 | Value of cell-available flag |
| par_err | output | 1 | Sticky parity error |
| rd_en | input | 1 | Downstream word read strobe |
| rd_data | output | DW | Word at the read position |
| rd_soc | output | 1 | First word of a cell at the read position |
| rd_avail | output | 1 | At least one complete cell is stored |

## Verification
A slip in the write word counter shows up on the read port as a data mismatch within the next cell read, or as rd_avail rising one word early or late. A wrong slot count shows up on clav_val at the very edge the fourth cell completes, and again when a fifth cell either appears or fails to appear after draining. Errors in the parity sense or in its stickiness show up on par_err one edge after the word in question. A late or early flag enable shows up one edge after each address change.

// File: rtl/cellport_pkg.sv
package cellport_pkg;
  function automatic int words_per_cell(input int dw);
    return (dw == 16) ? 27 : 53;
  endfunction
endpackage

// File: rtl/cellport_wr.sv
module cellport_wr #(
  parameter int DW  = 8,
  parameter int WPC = 53,
  localparam int CW = $clog2(WPC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_odd,
  input  logic          wen,
  input  logic          soc,
  input  logic [DW-1:0] data,
  input  logic          par,
  input  logic          space,
  output logic          we,
  output logic [CW-1:0] widx,
  output logic          commit,
  output logic          par_err
);
  logic          in_cell_q, in_cell_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic          err_q, err_d;
  logic          par_bad;

  always_comb begin
    par_bad   = (^data ^ par) != cfg_odd;
    err_d     = err_q | (wen & par_bad);
    in_cell_d = in_cell_q;
    wcnt_d    = wcnt_q;
    we        = 1'b0;
    widx      = wcnt_q;
    commit    = 1'b0;
    if (wen && soc) begin
      if (space) begin
        we        = 1'b1;
        widx      = '0;
        in_cell_d = 1'b1;
        wcnt_d    = CW'(1);
      end else begin
        in_cell_d = 1'b0;
        wcnt_d    = '0;
      end
    end else if (wen && in_cell_q) begin
      we = 1'b1;
      if (wcnt_q == CW'(WPC - 1)) begin
        commit    = 1'b1;
        in_cell_d = 1'b0;
        wcnt_d    = '0;
      end else begin
        wcnt_d = wcnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell_q <= 1'b0;
      wcnt_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      in_cell_q <= in_cell_d;
      wcnt_q    <= wcnt_d;
      err_q     <= err_d;
    end
  end

  assign par_err = err_q;

  // R6
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && ((^data ^ par) != cfg_odd)) |=> par_err);
  // R6
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err);
endmodule

// File: rtl/cellport_store.sv
module cellport_store #(
  parameter int DW    = 8,
  parameter int WPC   = 53,
  parameter int CELLS = 4,
  localparam int CW    = $clog2(WPC),
  localparam int SW    = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int NW    = $clog2(CELLS + 1),
  localparam int DEPTH = CELLS * WPC,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          commit,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_soc,
  output logic          rd_avail,
  output logic          space,
  output logic          space_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [SW-1:0] wslot_q, wslot_d, rslot_q, rslot_d;
  logic [CW-1:0] rcnt_q, rcnt_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] waddr, raddr;
  logic          rd_fire, rd_last;

  always_comb begin
    rd_fire = rd_en && (cnt_q != '0);
    rd_last = rd_fire && (rcnt_q == CW'(WPC - 1));
    waddr   = AW'(wslot_q) * AW'(WPC) + AW'(widx);
    raddr   = AW'(rslot_q) * AW'(WPC) + AW'(rcnt_q);
    wslot_d = wslot_q;
    rslot_d = rslot_q;
    rcnt_d  = rcnt_q;
    cnt_d   = cnt_q;
    if (commit) begin
      wslot_d = (wslot_q == SW'(CELLS - 1)) ? '0 : wslot_q + SW'(1);
    end
    if (rd_fire) begin
      if (rd_last) begin
        rcnt_d  = '0;
        rslot_d = (rslot_q == SW'(CELLS - 1)) ? '0 : rslot_q + SW'(1);
      end else begin
        rcnt_d = rcnt_q + CW'(1);
      end
    end
    if (commit && !rd_last) cnt_d = cnt_q + NW'(1);
    else if (!commit && rd_last) cnt_d = cnt_q - NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q <= '0;
      rslot_q <= '0;
      rcnt_q  <= '0;
      cnt_q   <= '0;
    end else begin
      wslot_q <= wslot_d;
      rslot_q <= rslot_d;
      rcnt_q  <= rcnt_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_data   = mem[raddr];
  assign rd_avail  = cnt_q != '0;
  assign rd_soc    = rd_avail && (rcnt_q == '0);
  assign space     = cnt_q < NW'(CELLS);
  assign space_nxt = cnt_d < NW'(CELLS);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(CELLS));
  // R8
  commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cnt_q < NW'(CELLS)));
  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_avail && !commit) |=> !rd_avail);
endmodule

// File: rtl/cellport_poll.sv
module cellport_poll #(
  parameter logic [4:0] PHY_ADDR = 5'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] addr,
  input  logic       space_nxt,
  output logic       clav_oe,
  output logic       clav_val
);
  logic match, oe_q, val_q, oe_d, val_d;

  always_comb begin
    match = addr == PHY_ADDR;
    oe_d  = match;
    val_d = match & space_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      val_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      val_q <= val_d;
    end
  end

  assign clav_oe  = oe_q;
  assign clav_val = val_q;

  // R2
  clav_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == PHY_ADDR) |=> clav_oe);
  // R2
  clav_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != PHY_ADDR) |=> !clav_oe);
endmodule

// File: rtl/cellport_tx.sv
module cellport_tx #(
  parameter int         DW       = 8,
  parameter int         CELLS    = 4,
  parameter logic [4:0] PHY_ADDR = 5'd3,
  localparam int WPC = cellport_pkg::words_per_cell(DW),
  localparam int CW  = $clog2(WPC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_odd,
  input  logic [4:0]    tx_addr,
  input  logic          tx_wen,
  input  logic          tx_soc,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_par,
  output logic          clav_oe,
  output logic          clav_val,
  output logic          par_err,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_soc,
  output logic          rd_avail
);
  logic [1:0]    rst_q;
  logic          rst_s_n;
  logic          we, commit, space, space_nxt;
  logic [CW-1:0] widx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  cellport_wr #(.DW(DW), .WPC(WPC)) u_wr (
    .clk(clk), .rst_n(rst_s_n), .cfg_odd(cfg_odd), .wen(tx_wen), .soc(tx_soc),
    .data(tx_data), .par(tx_par), .space(space), .we(we), .widx(widx),
    .commit(commit), .par_err(par_err)
  );

  cellport_store #(.DW(DW), .WPC(WPC), .CELLS(CELLS)) u_store (
    .clk(clk), .rst_n(rst_s_n), .we(we), .widx(widx), .wdata(tx_data),
    .commit(commit), .rd_en(rd_en), .rd_data(rd_data), .rd_soc(rd_soc),
    .rd_avail(rd_avail), .space(space), .space_nxt(space_nxt)
  );

  cellport_poll #(.PHY_ADDR(PHY_ADDR)) u_poll (
    .clk(clk), .rst_n(rst_s_n), .addr(tx_addr), .space_nxt(space_nxt),
    .clav_oe(clav_oe), .clav_val(clav_val)
  );
endmodule

// File: tb/cellport_tx_bench.sv
module cellport_tx_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_odd;
  logic [4:0]  tx_addr;
  logic        wen8, soc8, par8, rd8;
  logic [7:0]  data8, rdata8;
  logic        oe8, val8, err8, rsoc8, avail8;
  logic        wen16, soc16, par16, rd16;
  logic [15:0] data16, rdata16;
  logic        oe16, val16, err16, rsoc16, avail16;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  cellport_tx u_cellport_tx (
    .clk(clk), .rst_n(rst_n), .cfg_odd(cfg_odd), .tx_addr(tx_addr),
    .tx_wen(wen8), .tx_soc(soc8), .tx_data(data8), .tx_par(par8),
    .clav_oe(oe8), .clav_val(val8), .par_err(err8), .rd_en(rd8),
    .rd_data(rdata8), .rd_soc(rsoc8), .rd_avail(avail8)
  );

  cellport_tx #(.DW(16)) u_cellport_tx_w16 (
    .clk(clk), .rst_n(rst_n), .cfg_odd(cfg_odd), .tx_addr(tx_addr),
    .tx_wen(wen16), .tx_soc(soc16), .tx_data(data16), .tx_par(par16),
    .clav_oe(oe16), .clav_val(val16), .par_err(err16), .rd_en(rd16),
    .rd_data(rdata16), .rd_soc(rsoc16), .rd_avail(avail16)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 16 + i * 3 + 1);
  endfunction

  function automatic logic [15:0] pat16(input int seed, input int i);
    return {pat(seed, i), ~pat(seed + 1, i)};
  endfunction

  task automatic apply_reset;
    rst_n = 1'b0;
    wen8 = 0; soc8 = 0; par8 = 0; rd8 = 0; data8 = '0;
    wen16 = 0; soc16 = 0; par16 = 0; rd16 = 0; data16 = '0;
    tx_addr = 5'd7; cfg_odd = 1'b1;
    tick; tick;
    rst_n = 1'b1;
    tick; tick; tick;
  endtask

  // words first..last of cell 'seed'; soc on word 0; bad marks a parity-error word
  task automatic send8(input int seed, input int first, input int last, input int bad);
    for (int i = first; i <= last; i++) begin
      wen8 = 1'b1; soc8 = (i == 0); data8 = pat(seed, i);
      par8 = cfg_odd ? ~^data8 : ^data8;
      if (i == bad) par8 = ~par8;
      tick;
    end
    wen8 = 1'b0; soc8 = 1'b0;
  endtask

  task automatic read8(input int seed, input string req);
    for (int i = 0; i < 53; i++) begin
      chk(req, {24'b0, rdata8}, {24'b0, pat(seed, i)});
      if (i == 0 || i == 52) chk("R5 rd_soc", {31'b0, rsoc8}, {31'b0, (i == 0)});
      rd8 = 1'b1;
      tick;
    end
    rd8 = 1'b0;
  endtask

  task automatic t_reset;
    apply_reset;
    chk("R1 clav_oe", {31'b0, oe8}, 0);
    chk("R1 clav_val", {31'b0, val8}, 0);
    chk("R1 par_err", {31'b0, err8}, 0);
    chk("R1 rd_avail", {31'b0, avail8}, 0);
  endtask

  task automatic t_poll;
    apply_reset;
    tx_addr = 5'd3;
    chk("R2 before edge", {31'b0, oe8}, 0);
    tick;
    chk("R2 enable", {31'b0, oe8}, 1);
    chk("R3 empty store has room", {31'b0, val8}, 1);
    tx_addr = 5'd4;
    tick;
    chk("R2 release", {31'b0, oe8}, 0);
    chk("R3 quiet when not driven", {31'b0, val8}, 0);
  endtask

  task automatic t_single;
    apply_reset;
    send8(1, 0, 51, -1);
    chk("R4 not complete at word 52", {31'b0, avail8}, 0);
    send8(1, 52, 52, -1);
    chk("R4 complete after 53 words", {31'b0, avail8}, 1);
    read8(1, "R5 single cell data");
    chk("R5 store empty after read", {31'b0, avail8}, 0);
  endtask

  task automatic t_fill;
    apply_reset;
    tx_addr = 5'd3;
    for (int c = 10; c < 13; c++) send8(c, 0, 52, -1);
    send8(13, 0, 51, -1);
    chk("R3 room while fourth cell open", {31'b0, val8}, 1);
    send8(13, 52, 52, -1);
    chk("R3 full after fourth cell", {31'b0, val8}, 0);
    send8(14, 0, 52, -1);
    for (int c = 10; c < 14; c++) read8(c, "R8 stored cells intact");
    chk("R8 fifth cell dropped", {31'b0, avail8}, 0);
    chk("R3 room again after drain", {31'b0, val8}, 1);
  endtask

  task automatic t_midsoc;
    apply_reset;
    send8(20, 0, 19, -1);
    chk("R7 partial not visible", {31'b0, avail8}, 0);
    send8(21, 0, 52, -1);
    read8(21, "R7 restarted cell data");
    chk("R7 partial discarded", {31'b0, avail8}, 0);
  endtask

  task automatic t_ignore;
    apply_reset;
    for (int i = 0; i < 3; i++) begin
      wen8 = 1'b0; soc8 = 1'b1; data8 = 8'(i); tick;
    end
    soc8 = 1'b0;
    send8(30, 1, 52, -1);
    chk("R9 stray words ignored", {31'b0, avail8}, 0);
    rd8 = 1'b1; tick; tick; rd8 = 1'b0;
    send8(31, 0, 52, -1);
    chk("R10 read on empty ignored", {31'b0, rsoc8}, 1);
    read8(31, "R10 pointer unmoved by idle read");
    chk("R9 only one cell stored", {31'b0, avail8}, 0);
  endtask

  task automatic t_parity;
    apply_reset;
    cfg_odd = 1'b1;
    send8(40, 0, 4, -1);
    chk("R6 odd good words", {31'b0, err8}, 0);
    send8(40, 5, 5, 5);
    chk("R6 odd bad word flagged", {31'b0, err8}, 1);
    send8(40, 6, 52, -1);
    chk("R6 flag sticky", {31'b0, err8}, 1);
    read8(40, "R6 bad word still stored");
    apply_reset;
    cfg_odd = 1'b0;
    send8(41, 0, 52, -1);
    chk("R6 even good cell", {31'b0, err8}, 0);
    send8(42, 0, 0, 0);
    chk("R6 even bad word flagged", {31'b0, err8}, 1);
  endtask

  task automatic t_overlap;
    apply_reset;
    tx_addr = 5'd3;
    send8(50, 0, 52, -1);
    for (int i = 0; i < 53; i++) begin
      chk("R10 read while writing", {24'b0, rdata8}, {24'b0, pat(50, i)});
      wen8 = 1'b1; soc8 = (i == 0); data8 = pat(51, i); par8 = ~^data8;
      rd8 = 1'b1;
      tick;
    end
    wen8 = 1'b0; soc8 = 1'b0; rd8 = 1'b0;
    chk("R10 count kept at one", {31'b0, avail8}, 1);
    read8(51, "R10 second cell data");
    chk("R10 empty after both", {31'b0, avail8}, 0);
  endtask

  task automatic t_wide;
    apply_reset;
    for (int i = 0; i < 27; i++) begin
      wen16 = 1'b1; soc16 = (i == 0); data16 = pat16(60, i); par16 = ~^data16;
      tick;
      if (i == 25) chk("R4 wide not complete at 26", {31'b0, avail16}, 0);
    end
    wen16 = 1'b0; soc16 = 1'b0;
    chk("R4 wide complete after 27 words", {31'b0, avail16}, 1);
    chk("R6 wide parity clean", {31'b0, err16}, 0);
    for (int i = 0; i < 27; i++) begin
      chk("R5 wide data", {16'b0, rdata16}, {16'b0, pat16(60, i)});
      rd16 = 1'b1;
      tick;
    end
    rd16 = 1'b0;
    chk("R5 wide empty after read", {31'b0, avail16}, 0);
  endtask

  initial begin
    t_reset;
    t_poll;
    t_single;
    t_fill;
    t_midsoc;
    t_ignore;
    t_parity;
    t_overlap;
    t_wide;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule